// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Clear-to-Send Gating

This block sends bytes as asynchronous serial frames on one output line. Software writes a byte into a holding buffer. When the transmitter may start, the byte moves into a shift stage and goes out as one frame:

- a low start bit;
- eight data bits, least significant first;
- an optional parity bit;
- one or two high stop bits.

Because of the buffer, the next byte can be written while the current frame is still on the line, so consecutive frames can follow with no idle time between them.

A new frame may begin only at an evaluation point. The line is checked at every idle cycle and at the closing edge of each frame's last stop bit. At that point the transmit enable input, the buffer state and, when selected, the active-low clear-to-send input must all permit a start. A frame already on the line always completes.

The bit period is sixteen times (divider + 1) ticks of the count source. The count source is either the block clock or an external tick input. There are two status outputs, one for the holding buffer and one for the shift stage, and a sticky transmit interrupt request that is set each time the buffer is handed to the shift stage.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After synchronous reset, `txd` is 1, `buf_empty` is 1, `shreg_empty` is 1 and `irq_req` is 0.
- R2: A frame is a start bit (0), data bits D0 first up to D7, the parity bit if enabled, then the stop bits (1). With `cfg_ext_src`=0, each bit lasts exactly 16*(`cfg_div`+1) clock cycles, where `cfg_div` is sampled when the frame starts.
- R3: With `cfg_ext_src`=1, the count source is the `ext_tick` pulse train, so each bit lasts 16*(`cfg_div`+1) `ext_tick` pulses.
- R4: With `cfg_par_en`=1, the parity bit is the XOR of the data bits when `cfg_par_odd`=0 (even parity), and its inverse when `cfg_par_odd`=1 (odd parity).
- R5: With `cfg_par_en`=0, no parity bit is sent. With `cfg_two_stop`=1, two stop bits are sent instead of one.
- R6: A write (`wr_valid`=1) clears `buf_empty` at the next clock edge. The hand-over to the shift stage sets `buf_empty`, clears `shreg_empty` and drives the start bit, all at one edge.
- R7: `shreg_empty` rises at the edge that ends the last stop bit when no frame follows, and `txd` is 1 whenever `shreg_empty` is 1.
- R8: While `tx_enable`=0 at an evaluation point, no frame starts even with a full buffer. `txd` stays 1 and `buf_empty` stays 0. The held frame starts one edge after `tx_enable` returns to 1.
- R9: With `cfg_cts_sel`=1 and `cts_n`=1 at an evaluation point, no frame starts. The held frame starts one edge after `cts_n` goes low. A rise of `cts_n` during a frame does not cut that frame short.
- R10: With `cfg_cts_sel`=0, the value of `cts_n` has no effect on starting.
- R11: If the buffer was refilled before a frame ends, the next start bit begins at the edge that ends the previous last stop bit, with no idle cycle, and `shreg_empty` stays 0.
- R12: `irq_req` is set at each hand-over and stays set until `irq_ack` or `irq_clr` is 1 at a clock edge. A hand-over in the same cycle as a clear leaves it set.
- R13: A write in the same cycle as a hand-over sends the old byte and keeps the new byte in the buffer (`buf_empty` stays 0). The new byte follows back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Baud divider value n |
| cfg_ext_src | input | 1 | 1 selects `ext_tick` as count source |
| ext_tick | input | 1 | External count-source pulse, one clock wide |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_cts_sel | input | 1 | 1 makes `cts_n` gate frame starts |
| cts_n | input | 1 | Active-low clear to send |
| tx_enable | input | 1 | Transmit enable |
| wr_valid | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Byte to load into the buffer |
| irq_ack | input | 1 | Interrupt acknowledge, clears `irq_req` |
| irq_clr | input | 1 | Software clear of `irq_req` |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding buffer is empty |
| shreg_empty | output | 1 | Shift stage idle, no frame on the line |
| irq_req | output | 1 | Sticky transmit interrupt request |

## Verification
Two pairs of events can land on one edge.

The first pair is a buffer write and the hand-over of the previous byte. The bench holds `wr_valid` across the edge that loads the shift stage. It then expects both bytes on the line, back to back, with `buf_empty` low until the second hand-over.

The second pair is an interrupt clear and a hand-over. The bench raises `irq_clr` on the cycle of the hand-over and expects `irq_req` to read 1 afterwards.

Frame bits are judged at both the first and the last cycle of every bit period, so a period that is one cycle off, or any idle cycle at a frame join, shows up as a mismatch.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  function automatic logic parity_of(input logic [15:0] bits, input int unsigned width,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(width)) p = p ^ bits[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick
);
  localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;

  assign bit_tick = run && src_tick && (pre_q == div) && (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (run && src_tick) begin
      if (pre_q == div) begin
        pre_q <= '0;
        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  frame_cfg_t        cfg,
  input  logic [DIV_W-1:0]  div,
  input  logic              src_tick,
  output logic              txd,
  output logic              busy,
  output logic              frame_end
);
  localparam int TAIL_W = DATA_W + 3;
  localparam int CNT_W  = $clog2(TAIL_W + 1);

  logic [TAIL_W-1:0] tail_q, tail_new;
  logic [CNT_W-1:0]  left_q, left_new;
  logic [DIV_W-1:0]  div_q;
  logic              txd_q, busy_q, bit_tick;

  uart_tx_baud #(.DIV_W(DIV_W), .OVERSAMPLE(16)) u_baud (
    .clk(clk), .rst(rst), .run(busy_q), .restart(load),
    .src_tick(src_tick), .div(div_q), .bit_tick(bit_tick)
  );

  always_comb begin
    tail_new = '1;
    tail_new[DATA_W-1:0] = load_data;
    if (cfg.par_en)
      tail_new[DATA_W] = parity_of(16'(load_data), DATA_W, cfg.par_odd);
    left_new = CNT_W'(DATA_W + 1) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
  end

  assign frame_end = busy_q && bit_tick && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '1;
      left_q <= '0;
      div_q  <= '0;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (load) begin
      tail_q <= tail_new;
      left_q <= left_new;
      div_q  <= div;
      txd_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (frame_end) begin
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (busy_q && bit_tick) begin
      txd_q  <= tail_q[0];
      tail_q <= {1'b1, tail_q[TAIL_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_ext_src,
  input  logic              ext_tick,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_cts_sel,
  input  logic              cts_n,
  input  logic              tx_enable,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_ack,
  input  logic              irq_clr,
  output logic              txd,
  output logic              buf_empty,
  output logic              shreg_empty,
  output logic              irq_req
);
  logic [DATA_W-1:0] hold_q;
  logic              full_q, sh_empty_q, irq_q;
  logic              busy, frame_end, start_ok, load, src_tick;
  frame_cfg_t        fcfg;

  assign fcfg     = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign src_tick = cfg_ext_src ? ext_tick : 1'b1;
  assign start_ok = tx_enable && full_q && !(cfg_cts_sel && cts_n);
  // Evaluation point: any idle cycle, or the edge closing the last stop bit.
  assign load     = start_ok && (!busy || frame_end);

  uart_tx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(hold_q), .cfg(fcfg),
    .div(cfg_div), .src_tick(src_tick), .txd(txd), .busy(busy),
    .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      full_q     <= 1'b0;
      sh_empty_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      if (wr_valid) hold_q <= wr_data;
      full_q <= (full_q && !load) || wr_valid;
      if (load)           sh_empty_q <= 1'b0;
      else if (frame_end) sh_empty_q <= 1'b1;
      if (load)                    irq_q <= 1'b1;
      else if (irq_ack || irq_clr) irq_q <= 1'b0;
    end
  end

  assign buf_empty   = !full_q;
  assign shreg_empty = sh_empty_q;
  assign irq_req     = irq_q;

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tx_enable,
  input logic cfg_cts_sel,
  input logic cts_n,
  input logic wr_valid,
  input logic irq_ack,
  input logic irq_clr,
  input logic txd,
  input logic buf_empty,
  input logic shreg_empty,
  input logic irq_req
);
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !buf_empty);

  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    shreg_empty |-> txd);

  assert_disabled_idle_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_enable && shreg_empty) |=> shreg_empty);

  assert_handover_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> $past(tx_enable));

  assert_handover_needs_cts_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> !($past(cfg_cts_sel) && $past(cts_n)));

  assert_handover_sets_irq_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> irq_req);

  assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack && !irq_clr) |=> irq_req);

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst(rst), .tx_enable(tx_enable), .cfg_cts_sel(cfg_cts_sel),
  .cts_n(cts_n), .wr_valid(wr_valid), .irq_ack(irq_ack), .irq_clr(irq_clr),
  .txd(txd), .buf_empty(buf_empty), .shreg_empty(shreg_empty), .irq_req(irq_req)
);

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0]  cfg_div = '0;
  logic cfg_ext_src = 0, ext_tick = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic cfg_two_stop = 0, cfg_cts_sel = 0, cts_n = 0, tx_enable = 1;
  logic wr_valid = 0, irq_ack = 0, irq_clr = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic txd, buf_empty, shreg_empty, irq_req;
  logic ext_run = 0;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_tx_dbuf #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_uart_tx_dbuf (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_ext_src(cfg_ext_src),
    .ext_tick(ext_tick), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_cts_sel(cfg_cts_sel), .cts_n(cts_n),
    .tx_enable(tx_enable), .wr_valid(wr_valid), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq_clr(irq_clr), .txd(txd), .buf_empty(buf_empty),
    .shreg_empty(shreg_empty), .irq_req(irq_req)
  );

  initial forever begin
    @(negedge clk);
    ext_tick = ext_run ? ~ext_tick : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic pe,
                                            input logic po, input logic ts);
    logic [11:0] f;
    int k;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = d[i];
    k = 9;
    if (pe) begin
      f[k] = po ? ~(^d) : ^d;
      k++;
    end
    return f;
  endfunction

  function automatic int exp_len(input logic pe, input logic ts);
    return 10 + int'(pe) + int'(ts);
  endfunction

  // Entered at the first negedge of the start bit; returns at the first
  // negedge after the last stop bit.
  task automatic check_frame(input logic [7:0] d, input bit strict, input string req);
    logic [11:0] f;
    int nb, p;
    f  = exp_frame(d, cfg_par_en, cfg_par_odd, cfg_two_stop);
    nb = exp_len(cfg_par_en, cfg_two_stop);
    p  = 16 * (int'(cfg_div) + 1) * (cfg_ext_src ? 2 : 1);
    for (int k = 0; k < nb; k++) begin
      for (int c = 0; c < p; c++) begin
        if (strict ? (c == 0 || c == p - 1) : (c == p / 2)) begin
          n_checks++;
          if (txd !== f[k]) begin
            n_fail++;
            $display("FAIL %s: bit %0d cycle %0d actual %0b expected %0b", req, k, c, txd, f[k]);
          end
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 shreg_empty", shreg_empty, 1);
    chk("R1 irq_req", irq_req, 0);

    // R2 R4 R5 R6 R7: random formats and divider values
    for (int t = 0; t < 20; t++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cfg_div      = DIV_W'($urandom_range(0, 2));
      cfg_par_en   = 1'($urandom);
      cfg_par_odd  = 1'($urandom);
      cfg_two_stop = 1'($urandom);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      write_byte(d);
      chk("R6 buf_empty low after write", buf_empty, 0);
      chk("R6 line idle before start", txd, 1);
      @(negedge clk);
      chk("R6 buf_empty set at handover", buf_empty, 1);
      chk("R6 shreg_empty cleared at handover", shreg_empty, 0);
      chk("R12 irq set at handover", irq_req, 1);
      check_frame(d, 1, "R2/R4/R5 frame");
      chk("R7 shreg_empty after frame", shreg_empty, 1);
      chk("R7 line high after frame", txd, 1);
    end

    // R12 acknowledge clears the sticky bit
    chk("R12 irq sticky after frame", irq_req, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R12 irq_ack clears", irq_req, 0);

    // R8 enable gating
    cfg_div = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 0;
    tx_enable = 1'b0;
    write_byte(8'hA5);
    repeat (50) @(negedge clk);
    chk("R8 line idle while disabled", txd, 1);
    chk("R8 buffer held while disabled", buf_empty, 0);
    chk("R8 shreg idle while disabled", shreg_empty, 1);
    chk("R8 no irq while disabled", irq_req, 0);
    tx_enable = 1'b1;
    @(negedge clk);
    check_frame(8'hA5, 1, "R8 frame after enable");

    // R9 clear-to-send gating and no abort mid-frame
    cfg_cts_sel = 1'b1; cts_n = 1'b1; cfg_par_odd = 1;
    write_byte(8'h3C);
    repeat (40) @(negedge clk);
    chk("R9 line idle while cts high", txd, 1);
    chk("R9 buffer held while cts high", buf_empty, 0);
    cts_n = 1'b0;
    @(negedge clk);
    fork
      check_frame(8'h3C, 1, "R9 frame after cts low");
      begin
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    chk("R9 shreg_empty after full frame", shreg_empty, 1);

    // R10 cts ignored when not selected
    cfg_cts_sel = 1'b0;
    write_byte(8'h81);
    @(negedge clk);
    chk("R10 start despite cts high", shreg_empty, 0);
    check_frame(8'h81, 1, "R10 frame");
    cts_n = 1'b0;

    // R11 back-to-back frames
    cfg_div = 1; cfg_par_en = 0; cfg_two_stop = 1;
    write_byte(8'h5A);
    @(negedge clk);
    fork
      check_frame(8'h5A, 1, "R11 first frame");
      begin
        repeat (10) @(negedge clk);
        write_byte(8'hC3);
      end
    join
    chk("R11 no gap, shreg busy at join", shreg_empty, 0);
    check_frame(8'hC3, 1, "R11 second frame");
    chk("R11 idle after pair", shreg_empty, 1);

    // R13 write on the hand-over edge; R12 set wins over clear
    cfg_div = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 0;
    irq_clr = 1'b1;
    @(negedge clk);
    chk("R12 irq_clr clears", irq_req, 0);
    irq_clr = 1'b0;
    wr_valid = 1'b1; wr_data = 8'h11;
    @(negedge clk);
    wr_data = 8'hEE; irq_clr = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; irq_clr = 1'b0;
    chk("R12 set beats clear", irq_req, 1);
    chk("R13 buffer still full", buf_empty, 0);
    chk("R13 start bit", txd, 0);
    check_frame(8'h11, 1, "R13 old byte");
    check_frame(8'hEE, 1, "R13 new byte");
    chk("R13 idle after", shreg_empty, 1);

    // R3 external count source
    cfg_ext_src = 1'b1; ext_run = 1'b1; cfg_div = 0;
    repeat (4) @(negedge clk);
    write_byte(8'h96);
    @(negedge clk);
    check_frame(8'h96, 0, "R3 external source frame");
    repeat (4) @(negedge clk);
    chk("R3 idle after ext frame", shreg_empty, 1);
    ext_run = 1'b0;

    finish_run();
  end

endmodule